// File: doc/BRIEF.md
# Two-Region Playback Address Sequencer

This block produces the byte addresses for an audio playback stream that alternates between two memory regions. Software programs a start address and a byte length for region A and for region B through a small word-indexed register port, then sets the run bit. The block then issues fetch requests. Each acknowledged fetch advances the position by a fixed step. The block walks region A, then region B, and then wraps back to region A for as long as run stays set.

At the end of each region the block marks that region done in a sticky flag register and raises the interrupt line. Software clears a flag by writing a one to its bit. Clearing the run bit freezes the position in place, and setting it again continues from that position. The first time run is set after reset, the block loads region A's start address.

Top module: `pingpong_dma_seq`

## Requirements
- R1: After reset the flag register (index 5) reads 0x00000001. Every other register reads 0, irq is low and fetch_req is low.
- R2: Register indices are: 0 control (bit 0 = run), 1 start A, 2 start B, 3 length A, 4 length B, 5 flags, 6 current address (read-only), 7 current offset (read-only), 8 summary (read-only). The length registers keep only the low 16 bits of a write.
- R3: The first time run is set after reset, region A's start address is loaded one cycle after the write. From the next cycle fetch_req is high, fetch_addr equals start A and the offset is 0.
- R4: Each cycle with fetch_req and fetch_ack both high advances fetch_addr and the offset by STEP_BYTES (4 by default), unless that step reaches the active region's length.
- R5: When offset + STEP_BYTES is greater than or equal to the active region's length, the accepted fetch moves fetch_addr to the other region's start and the offset to 0. On the same edge it sets flag bit 1 if region A finished, or flag bit 2 if region B finished.
- R6: After region B the sequence wraps back to region A's start.
- R7: With run cleared, fetch_req is low and fetch_ack is ignored, so the position is held. Setting run again resumes at the held position.
- R8: Writing the flag register clears each flag whose bit is 1 in the write data and leaves the others unchanged. Writing all ones clears every flag, including bit 0.
- R9: irq and bit 0 of the summary register are high exactly when flag bit 1 or flag bit 2 is set. Bit 0 of the flag register has no effect on either.
- R10: When a region completes in the same cycle that software writes a one to that region's flag bit, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| fetch_req | output | 1 | Fetch request toward memory |
| fetch_addr | output | 32 | Byte address of the requested fetch |
| fetch_ack | input | 1 | Fetch accepted by memory |
| irq | output | 1 | Pending region-done interrupt |

## Verification
A bad position register shows up on fetch_addr and on the offset register on the first accepted fetch after the fault. A missed region switch shows up as an address running past the region end. A flag that fails to set or fails to clear shows on irq and on the summary bit on the cycle after the edge that should have changed it. The tests therefore sample after every accepted fetch, every register write, and every pause and resume. They also cover the cases where a completion and an acknowledge write collide, and where fetch_ack arrives while the block is paused.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    localparam int REG_IDX_W = 4;

    localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 4'd0;
    localparam logic [REG_IDX_W-1:0] IDX_START_A = 4'd1;
    localparam logic [REG_IDX_W-1:0] IDX_START_B = 4'd2;
    localparam logic [REG_IDX_W-1:0] IDX_LEN_A   = 4'd3;
    localparam logic [REG_IDX_W-1:0] IDX_LEN_B   = 4'd4;
    localparam logic [REG_IDX_W-1:0] IDX_FLAGS   = 4'd5;
    localparam logic [REG_IDX_W-1:0] IDX_POS     = 4'd6;
    localparam logic [REG_IDX_W-1:0] IDX_OFS     = 4'd7;
    localparam logic [REG_IDX_W-1:0] IDX_SUMMARY = 4'd8;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_MISC = 0;
    localparam int FLAG_DONE_A = 1;
    localparam int FLAG_DONE_B = 2;
    localparam logic [NUM_FLAGS-1:0] FLAGS_RESET = 3'b001;

    typedef enum logic {
        REGION_A = 1'b0,
        REGION_B = 1'b1
    } region_e;
endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 run,
    output logic [ADDR_W-1:0]    start_a,
    output logic [ADDR_W-1:0]    start_b,
    output logic [LEN_W-1:0]     len_a,
    output logic [LEN_W-1:0]     len_b
);
    typedef struct packed {
        logic              run;
        logic [ADDR_W-1:0] start_a;
        logic [ADDR_W-1:0] start_b;
        logic [LEN_W-1:0]  len_a;
        logic [LEN_W-1:0]  len_b;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (idx)
                IDX_CTRL:    cfg_d.run     = wdata[0];
                IDX_START_A: cfg_d.start_a = wdata[ADDR_W-1:0];
                IDX_START_B: cfg_d.start_b = wdata[ADDR_W-1:0];
                IDX_LEN_A:   cfg_d.len_a   = wdata[LEN_W-1:0];
                IDX_LEN_B:   cfg_d.len_b   = wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign run     = cfg_q.run;
    assign start_a = cfg_q.start_a;
    assign start_b = cfg_q.start_b;
    assign len_a   = cfg_q.len_a;
    assign len_b   = cfg_q.len_b;

    AST_RUN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_CTRL) |=> (run == $past(wdata[0]))); // R7
endmodule

// File: rtl/pp_walker.sv
module pp_walker
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] start_a,
    input  logic [ADDR_W-1:0] start_b,
    input  logic [LEN_W-1:0]  len_a,
    input  logic [LEN_W-1:0]  len_b,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_ofs,
    output logic              done_a,
    output logic              done_b
);
    localparam logic [LEN_W:0]    STEP_OFS  = (LEN_W+1)'(STEP_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(STEP_BYTES);

    typedef struct packed {
        logic              loaded;
        region_e           region;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  ofs;
    } walk_t;

    walk_t st_d, st_q;
    logic [LEN_W:0] ofs_next;
    logic [LEN_W:0] limit;
    logic           accept;

    assign accept = st_q.loaded && run && fetch_ack;

    always_comb begin
        st_d     = st_q;
        done_a   = 1'b0;
        done_b   = 1'b0;
        ofs_next = {1'b0, st_q.ofs} + STEP_OFS;
        limit    = (st_q.region == REGION_B) ? {1'b0, len_b} : {1'b0, len_a};
        if (!st_q.loaded) begin
            if (run) begin
                st_d.loaded = 1'b1;
                st_d.region = REGION_A;
                st_d.addr   = start_a;
                st_d.ofs    = '0;
            end
        end else if (accept) begin
            if (ofs_next >= limit) begin
                st_d.ofs = '0;
                if (st_q.region == REGION_A) begin
                    st_d.region = REGION_B;
                    st_d.addr   = start_b;
                    done_a      = 1'b1;
                end else begin
                    st_d.region = REGION_A;
                    st_d.addr   = start_a;
                    done_b      = 1'b1;
                end
            end else begin
                st_d.addr = st_q.addr + STEP_ADDR;
                st_d.ofs  = ofs_next[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_req = st_q.loaded && run;
    assign cur_addr  = st_q.addr;
    assign cur_ofs   = st_q.ofs;

    AST_OFS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.ofs == '0) || (st_q.ofs == $past(st_q.ofs) + LEN_W'(STEP_BYTES))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.loaded && !(run && fetch_ack)) |=> ($stable(st_q.addr) && $stable(st_q.ofs))); // R7
    AST_DONE_A_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_a |=> (st_q.region == REGION_B && st_q.ofs == '0)); // R5
    AST_DONE_B_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_b |=> (st_q.region == REGION_A && st_q.ofs == '0)); // R6
endmodule

// File: rtl/pp_irq_flags.sv
module pp_irq_flags
    import pp_dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [NUM_FLAGS-1:0] wbits,
    input  logic                 done_a,
    input  logic                 done_b,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] flags_d, flags_q;
    logic [NUM_FLAGS-1:0] clr_v, set_v;

    always_comb begin
        clr_v = (we && idx == IDX_FLAGS) ? wbits : '0;
        set_v = '0;
        set_v[FLAG_DONE_A] = done_a;
        set_v[FLAG_DONE_B] = done_b;
        flags_d = (flags_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RESET;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign irq   = flags_q[FLAG_DONE_A] | flags_q[FLAG_DONE_B];

    AST_SET_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
        done_a |=> flags_q[FLAG_DONE_A]); // R10
    AST_SET_WINS_B: assert property (@(posedge clk) disable iff (!rst_n)
        done_b |=> flags_q[FLAG_DONE_B]); // R10
    AST_W1C_A: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[FLAG_DONE_A] && !done_a) |=> !flags_q[FLAG_DONE_A]); // R8
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v == '0 && !done_a && !done_b) |=> $stable(flags_q)); // R8
endmodule

// File: rtl/pingpong_dma_seq.sv
module pingpong_dma_seq
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    output logic              irq
);
    logic                 run;
    logic [ADDR_W-1:0]    start_a, start_b, cur_addr;
    logic [LEN_W-1:0]     len_a, len_b, cur_ofs;
    logic                 done_a, done_b;
    logic [NUM_FLAGS-1:0] flags;

    pp_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_addr), .wdata(reg_wdata),
        .run(run), .start_a(start_a), .start_b(start_b), .len_a(len_a), .len_b(len_b)
    );

    pp_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP_BYTES(STEP_BYTES)) u_walk (
        .clk(clk), .rst_n(rst_n), .run(run), .start_a(start_a), .start_b(start_b),
        .len_a(len_a), .len_b(len_b), .fetch_ack(fetch_ack), .fetch_req(fetch_req),
        .cur_addr(cur_addr), .cur_ofs(cur_ofs), .done_a(done_a), .done_b(done_b)
    );

    pp_irq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_addr),
        .wbits(reg_wdata[NUM_FLAGS-1:0]), .done_a(done_a), .done_b(done_b),
        .flags(flags), .irq(irq)
    );

    assign fetch_addr = cur_addr;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            IDX_CTRL:    reg_rdata[0]            = run;
            IDX_START_A: reg_rdata[ADDR_W-1:0]   = start_a;
            IDX_START_B: reg_rdata[ADDR_W-1:0]   = start_b;
            IDX_LEN_A:   reg_rdata[LEN_W-1:0]    = len_a;
            IDX_LEN_B:   reg_rdata[LEN_W-1:0]    = len_b;
            IDX_FLAGS:   reg_rdata[NUM_FLAGS-1:0] = flags;
            IDX_POS:     reg_rdata[ADDR_W-1:0]   = cur_addr;
            IDX_OFS:     reg_rdata[LEN_W-1:0]    = cur_ofs;
            IDX_SUMMARY: reg_rdata[0]            = irq;
            default: ;
        endcase
    end

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> run); // R7
endmodule

// File: tb/pingpong_dma_seq_tb.sv
module pingpong_dma_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pingpong_dma_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic ack1();
        @(negedge clk);
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 4'd0, 32'h0);
        rd_chk("R1 startA", 4'd1, 32'h0);
        rd_chk("R1 flags", 4'd5, 32'h1);
        rd_chk("R1 pos", 4'd6, 32'h0);
        rd_chk("R1 summary", 4'd8, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 req", {31'b0, fetch_req}, 32'h0);
    endtask

    task automatic t_program();
        wr(4'd1, 32'h0000_1000);
        wr(4'd2, 32'h0000_2000);
        wr(4'd3, 32'h1234_0008);
        wr(4'd4, 32'h0000_000C);
        rd_chk("R2 lenA low16", 4'd3, 32'h8);
        rd_chk("R2 startB", 4'd2, 32'h2000);
    endtask

    task automatic t_start();
        wr(4'd0, 32'h1);
        chk("R3 req during load", {31'b0, fetch_req}, 32'h0);
        @(negedge clk);
        chk("R3 req", {31'b0, fetch_req}, 32'h1);
        chk("R3 addr", fetch_addr, 32'h1000);
        rd_chk("R3 ofs", 4'd7, 32'h0);
    endtask

    task automatic t_step_and_switch();
        ack1();
        chk("R4 addr", fetch_addr, 32'h1004);
        rd_chk("R4 ofs", 4'd7, 32'h4);
        chk("R9 irq before done", {31'b0, irq}, 32'h0);
        ack1();
        chk("R5 addr B", fetch_addr, 32'h2000);
        rd_chk("R5 ofs", 4'd7, 32'h0);
        rd_chk("R5 flags", 4'd5, 32'h3);
        chk("R9 irq", {31'b0, irq}, 32'h1);
        rd_chk("R9 summary", 4'd8, 32'h1);
    endtask

    task automatic t_ack();
        wr(4'd5, 32'h0);
        rd_chk("R8 zero write", 4'd5, 32'h3);
        wr(4'd5, 32'h4);
        rd_chk("R8 other bit", 4'd5, 32'h3);
        wr(4'd5, 32'h2);
        rd_chk("R8 clear A", 4'd5, 32'h1);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);
        rd_chk("R9 bit0 no summary", 4'd8, 32'h0);
    endtask

    task automatic t_wrap();
        ack1();
        ack1();
        chk("R4 addr B+8", fetch_addr, 32'h2008);
        ack1();
        chk("R6 wrap addr", fetch_addr, 32'h1000);
        rd_chk("R6 flags", 4'd5, 32'h5);
        chk("R6 irq", {31'b0, irq}, 32'h1);
        wr(4'd5, 32'hFFFF_FFFF);
        rd_chk("R8 all ones", 4'd5, 32'h0);
        chk("R8 irq off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_pause();
        ack1();
        chk("R4 addr A+4", fetch_addr, 32'h1004);
        wr(4'd0, 32'h0);
        chk("R7 req off", {31'b0, fetch_req}, 32'h0);
        ack1();
        chk("R7 hold addr", fetch_addr, 32'h1004);
        rd_chk("R7 hold ofs", 4'd7, 32'h4);
        wr(4'd0, 32'h1);
        chk("R7 resume req", {31'b0, fetch_req}, 32'h1);
        chk("R7 resume addr", fetch_addr, 32'h1004);
    endtask

    task automatic t_collide();
        @(negedge clk);
        fetch_ack = 1'b1;
        reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h2;
        @(negedge clk);
        fetch_ack = 1'b0; reg_we = 1'b0;
        rd_chk("R10 set wins", 4'd5, 32'h2);
        chk("R10 addr", fetch_addr, 32'h2000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_start();
        t_step_and_switch();
        t_ack();
        t_wrap();
        t_pause();
        t_collide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule